// File: doc/BRIEF.md
# Trap Cause Detection Unit

This block gathers exception conditions raised along a 32-bit, five-stage integer pipeline and turns them into a single trap request. Each stage presents its own fault information:

- **Fetch:** the program counter and the bus response for the instruction read.
- **Decode:** illegal, breakpoint and environment-call flags, plus the current privilege level.
- **Execute:** a flag for an undefined CSR access.
- **Memory:** the data address, access size, access kind and bus response.

Every cycle the unit looks at all stages at once. It keeps only the exception of the oldest instruction in flight and reports it one clock later. The report carries a trap-valid pulse, a cause code and a trap value. A flush request goes out in the same cycle so that younger pipeline stages are squashed.

Both bus responses use the usual AXI encoding. Only 2'b00 (OKAY) counts as success. Any other code is an access fault, and that includes exclusive-OK. Each stage input is qualified by its own valid bit.

Top module: `trap_cause_unit`

## Requirements
- R1: A valid fetch whose PC bits [1:0] are not 2'b00 yields cause 0 with the trap value equal to the fetch PC.
- R2: A valid fetch with an aligned PC and a non-OKAY response yields cause 1 with the trap value equal to the fetch PC. A misaligned PC takes precedence over a bad response in the same fetch.
- R3: Response codes are 2'b00 OKAY, 2'b01 EXOKAY, 2'b10 SLVERR and 2'b11 DECERR. On both the fetch and the data bus, every code except 2'b00 is treated as an access fault.
- R4: A valid decode with the illegal flag, or a valid execute with the bad-CSR flag, yields cause 2 with trap value zero.
- R5: A valid decode with the break flag and no illegal flag yields cause 3 with the trap value equal to the decode PC.
- R6: A valid decode with only the environment-call flag yields a cause that depends on the privilege level, and a trap value of zero. Privilege 2'b00 (user) gives cause 8, 2'b01 (supervisor) gives cause 9, and 2'b11 (machine) gives cause 11. The reserved code 2'b10 is treated as machine.
- R7: A valid memory access is misaligned in these cases: a halfword (size 2'b01) with address bit 0 set, or a word (size 2'b10 or 2'b11) with either of address bits [1:0] set. A byte access (size 2'b00) is never misaligned. A misaligned load (kind 2'b00) yields cause 4. A misaligned store or AMO (any other kind) yields cause 6. In both cases the trap value is the address.
- R8: An aligned, valid memory access with a non-OKAY response yields cause 5 for a load and cause 7 for a store or AMO, with the address as the trap value. Misalignment takes precedence over a bad response.
- R9: When several stages flag an exception in the same cycle, the report comes from the oldest stage. Memory beats execute, execute beats decode, and decode beats fetch. Within decode, illegal beats break, and break beats environment call.
- R10: A stage whose valid input is low contributes no exception, whatever its other inputs carry.
- R11: Outputs are registered: the trap for inputs presented in one cycle appears after the next rising clock edge. When no trap is reported, the cause and the trap value are both zero.
- R12: The flush output equals the trap-valid output in every cycle.
- R13: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch stage holds an instruction |
| fetch_pc_i | input | 32 | Fetch program counter |
| fetch_resp_i | input | 2 | Bus response of the instruction read |
| dec_valid_i | input | 1 | Decode stage holds an instruction |
| dec_pc_i | input | 32 | Program counter of the decoded instruction |
| dec_illegal_i | input | 1 | Undefined or unimplemented opcode |
| dec_break_i | input | 1 | Breakpoint instruction |
| dec_ecall_i | input | 1 | Environment-call instruction |
| priv_i | input | 2 | Current privilege level |
| exe_valid_i | input | 1 | Execute stage holds an instruction |
| exe_csr_bad_i | input | 1 | Access to an undefined CSR |
| mem_valid_i | input | 1 | Memory stage holds an access |
| mem_addr_i | input | 32 | Data address |
| mem_size_i | input | 2 | Access size: 0 byte, 1 half, 2 or 3 word |
| mem_kind_i | input | 2 | 0 load, any other value store or AMO |
| mem_resp_i | input | 2 | Bus response of the data access |
| trap_valid_o | output | 1 | Trap request, one cycle per faulting cycle |
| trap_cause_o | output | 4 | Exception cause code |
| trap_value_o | output | 32 | Faulting PC, faulting address, or zero |
| flush_o | output | 1 | Squash the younger pipeline stages |

## Verification
A wrong stage candidate or a wrong priority choice shows at the ports one clock after the stimulus. It appears as a wrong cause code, a trap value taken from the wrong source, or a missing or spurious trap pulse. The output register is the only state, so no fault can hide for longer than one cycle. Sweeping every combination of low address bits, size, kind, response and privilege, together with all sixteen overlaps of the four stages, therefore exposes each error at the edge that follows it.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned CAUSE_W = 4;
  localparam int unsigned NSTAGE  = 4;  // index 0 = oldest

  localparam logic [1:0] RESP_OKAY = 2'b00;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;

  localparam logic [1:0] KIND_LOAD = 2'b00;

  typedef enum logic [CAUSE_W-1:0] {
    C_IMISAL  = 4'd0,
    C_IFAULT  = 4'd1,
    C_ILLEGAL = 4'd2,
    C_BREAK   = 4'd3,
    C_LMISAL  = 4'd4,
    C_LFAULT  = 4'd5,
    C_SMISAL  = 4'd6,
    C_SFAULT  = 4'd7,
    C_ECALL_U = 4'd8,
    C_ECALL_S = 4'd9,
    C_ECALL_M = 4'd11
  } cause_e;

  typedef struct packed {
    logic            hit;
    cause_e          cause;
    logic [XLEN-1:0] tval;
  } cand_t;

  function automatic logic resp_bad(input logic [1:0] r);
    return r != RESP_OKAY;
  endfunction
endpackage

// File: rtl/trap_fetch_chk.sv
module trap_fetch_chk
  import trap_pkg::*;
(
  input  logic            valid_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [1:0]      resp_i,
  output cand_t           cand_o
);
  always_comb begin
    cand_o = '{hit: 1'b0, cause: C_IMISAL, tval: '0};
    if (valid_i) begin
      if (pc_i[1:0] != 2'b00) begin
        cand_o = '{hit: 1'b1, cause: C_IMISAL, tval: pc_i};
      end else if (resp_bad(resp_i)) begin
        cand_o = '{hit: 1'b1, cause: C_IFAULT, tval: pc_i};
      end
    end
  end

  always_comb begin
    if (valid_i && pc_i[1:0] == 2'b00 && resp_i != 2'b00)
      a_r2_fetch_fault: assert (cand_o.hit && cand_o.cause == C_IFAULT);
  end
endmodule

// File: rtl/trap_dec_chk.sv
module trap_dec_chk
  import trap_pkg::*;
(
  input  logic            valid_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            illegal_i,
  input  logic            break_i,
  input  logic            ecall_i,
  input  logic [1:0]      priv_i,
  output cand_t           cand_o
);
  cause_e ecall_cause;

  always_comb begin
    unique case (priv_i)
      PRIV_U:  ecall_cause = C_ECALL_U;
      PRIV_S:  ecall_cause = C_ECALL_S;
      default: ecall_cause = C_ECALL_M;  // reserved level folds to machine
    endcase
  end

  always_comb begin
    cand_o = '{hit: 1'b0, cause: C_IMISAL, tval: '0};
    if (valid_i) begin
      if (illegal_i)     cand_o = '{hit: 1'b1, cause: C_ILLEGAL, tval: '0};
      else if (break_i)  cand_o = '{hit: 1'b1, cause: C_BREAK,   tval: pc_i};
      else if (ecall_i)  cand_o = '{hit: 1'b1, cause: ecall_cause, tval: '0};
    end
  end

  always_comb begin
    if (valid_i && ecall_i && !illegal_i && !break_i)
      a_r6_ecall_class: assert (cand_o.hit && (cand_o.cause == C_ECALL_U ||
                                cand_o.cause == C_ECALL_S || cand_o.cause == C_ECALL_M));
  end
endmodule

// File: rtl/trap_mem_chk.sv
module trap_mem_chk
  import trap_pkg::*;
(
  input  logic            valid_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [1:0]      size_i,
  input  logic [1:0]      kind_i,
  input  logic [1:0]      resp_i,
  output cand_t           cand_o
);
  logic misal, is_store;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = addr_i[0];
      default: misal = |addr_i[1:0];
    endcase
  end

  assign is_store = kind_i != KIND_LOAD;

  always_comb begin
    cand_o = '{hit: 1'b0, cause: C_IMISAL, tval: '0};
    if (valid_i) begin
      if (misal)
        cand_o = '{hit: 1'b1, cause: is_store ? C_SMISAL : C_LMISAL, tval: addr_i};
      else if (resp_bad(resp_i))
        cand_o = '{hit: 1'b1, cause: is_store ? C_SFAULT : C_LFAULT, tval: addr_i};
    end
  end

  always_comb begin
    if (valid_i && size_i == 2'b01 && addr_i[0])
      a_r7_half_misal: assert (cand_o.hit && (cand_o.cause == C_LMISAL || cand_o.cause == C_SMISAL));
    if (valid_i && size_i == 2'b00 && resp_i == 2'b00)
      a_r7_byte_never_misal: assert (!cand_o.hit);
  end
endmodule

// File: rtl/trap_pick.sv
module trap_pick
  import trap_pkg::*;
(
  input  cand_t cand_i [NSTAGE],
  output cand_t sel_o
);
  // Scan youngest to oldest so the oldest hit overwrites.
  always_comb begin
    sel_o = '{hit: 1'b0, cause: C_IMISAL, tval: '0};
    for (int i = NSTAGE - 1; i >= 0; i--) begin
      if (cand_i[i].hit) sel_o = cand_i[i];
    end
  end

  always_comb begin
    if (cand_i[0].hit) a_r9_oldest_wins: assert (sel_o == cand_i[0]);
  end
endmodule

// File: rtl/trap_cause_unit.sv
module trap_cause_unit
  import trap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_valid_i,
  input  logic [XLEN-1:0]    fetch_pc_i,
  input  logic [1:0]         fetch_resp_i,
  input  logic               dec_valid_i,
  input  logic [XLEN-1:0]    dec_pc_i,
  input  logic               dec_illegal_i,
  input  logic               dec_break_i,
  input  logic               dec_ecall_i,
  input  logic [1:0]         priv_i,
  input  logic               exe_valid_i,
  input  logic               exe_csr_bad_i,
  input  logic               mem_valid_i,
  input  logic [XLEN-1:0]    mem_addr_i,
  input  logic [1:0]         mem_size_i,
  input  logic [1:0]         mem_kind_i,
  input  logic [1:0]         mem_resp_i,
  output logic               trap_valid_o,
  output logic [CAUSE_W-1:0] trap_cause_o,
  output logic [XLEN-1:0]    trap_value_o,
  output logic               flush_o
);
  localparam int unsigned S_MEM = 0, S_EXE = 1, S_DEC = 2, S_FET = 3;

  cand_t cand [NSTAGE];
  cand_t sel;

  trap_mem_chk u_mem (
    .valid_i(mem_valid_i), .addr_i(mem_addr_i), .size_i(mem_size_i),
    .kind_i(mem_kind_i), .resp_i(mem_resp_i), .cand_o(cand[S_MEM])
  );

  assign cand[S_EXE] = '{hit: exe_valid_i && exe_csr_bad_i, cause: C_ILLEGAL, tval: '0};

  trap_dec_chk u_dec (
    .valid_i(dec_valid_i), .pc_i(dec_pc_i), .illegal_i(dec_illegal_i),
    .break_i(dec_break_i), .ecall_i(dec_ecall_i), .priv_i(priv_i),
    .cand_o(cand[S_DEC])
  );

  trap_fetch_chk u_fet (
    .valid_i(fetch_valid_i), .pc_i(fetch_pc_i), .resp_i(fetch_resp_i),
    .cand_o(cand[S_FET])
  );

  trap_pick u_pick (.cand_i(cand), .sel_o(sel));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_valid_o <= 1'b0;
      trap_cause_o <= '0;
      trap_value_o <= '0;
    end else begin
      trap_valid_o <= sel.hit;
      trap_cause_o <= sel.hit ? sel.cause : '0;
      trap_value_o <= sel.hit ? sel.tval  : '0;
    end
  end

  assign flush_o = trap_valid_o;

  a_r9_mem_beats_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand[S_MEM].hit |=> trap_valid_o && trap_cause_o >= 4'd4 && trap_cause_o <= 4'd7);

  a_r1_fetch_misal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_pc_i[1:0] != 2'b00 && !cand[S_MEM].hit &&
     !cand[S_EXE].hit && !cand[S_DEC].hit)
    |=> trap_cause_o == 4'd0 && trap_value_o == $past(fetch_pc_i));

  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_o |-> trap_cause_o == '0 && trap_value_o == '0);

  a_r10_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_valid_i && !dec_valid_i && !exe_valid_i && !mem_valid_i) |=> !trap_valid_o);
endmodule

// File: tb/trap_cause_unit_tb.sv
module trap_cause_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic        fv = 0, dv = 0, ill = 0, brk = 0, ecl = 0, ev = 0, csr = 0, mv = 0;
  logic [31:0] fpc = 0, dpc = 0, maddr = 0;
  logic [1:0]  fr = 0, prv = 0, msz = 0, mk = 0, mr = 0;
  logic        t_v, t_fl;
  logic [3:0]  t_c;
  logic [31:0] t_val;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trap_cause_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fv), .fetch_pc_i(fpc), .fetch_resp_i(fr),
    .dec_valid_i(dv), .dec_pc_i(dpc), .dec_illegal_i(ill), .dec_break_i(brk),
    .dec_ecall_i(ecl), .priv_i(prv),
    .exe_valid_i(ev), .exe_csr_bad_i(csr),
    .mem_valid_i(mv), .mem_addr_i(maddr), .mem_size_i(msz), .mem_kind_i(mk),
    .mem_resp_i(mr),
    .trap_valid_o(t_v), .trap_cause_o(t_c), .trap_value_o(t_val), .flush_o(t_fl)
  );

  task automatic expect_now(string tag, bit ev_, logic [3:0] ec, logic [31:0] et);
    total++;
    if (t_v !== ev_ || t_c !== ec || t_val !== et || t_fl !== ev_) begin
      bad++;
      $display("FAIL %s: got v=%0b c=%0d val=%h fl=%0b, exp v=%0b c=%0d val=%h fl=%0b",
               tag, t_v, t_c, t_val, t_fl, ev_, ec, et, ev_);
    end
  endtask

  // Expected result from the requirements, oldest stage first.
  task automatic model(output bit v, output logic [3:0] c, output logic [31:0] t);
    bit mis;
    v = 1; c = 0; t = 0;
    mis = (msz == 2'd1) ? maddr[0] : (msz >= 2'd2) ? (maddr[1:0] != 0) : 1'b0;
    if (mv && mis)                   begin c = (mk != 0) ? 4'd6 : 4'd4; t = maddr; end
    else if (mv && mr != 0)          begin c = (mk != 0) ? 4'd7 : 4'd5; t = maddr; end
    else if (ev && csr)              c = 4'd2;
    else if (dv && ill)              c = 4'd2;
    else if (dv && brk)              begin c = 4'd3; t = dpc; end
    else if (dv && ecl)              c = (prv == 0) ? 4'd8 : (prv == 1) ? 4'd9 : 4'd11;
    else if (fv && fpc[1:0] != 0)    begin c = 4'd0; t = fpc; end
    else if (fv && fr != 0)          begin c = 4'd1; t = fpc; end
    else v = 0;
  endtask

  // Inputs are stable here; result appears after the next rising edge.
  task automatic step(string tag);
    bit v; logic [3:0] c; logic [31:0] t;
    model(v, c, t);
    @(posedge clk); #1;
    expect_now(tag, v, c, t);
  endtask

  task automatic clear();
    fv = 0; dv = 0; ill = 0; brk = 0; ecl = 0; ev = 0; csr = 0; mv = 0;
    fr = 0; mr = 0; msz = 0; mk = 0; prv = 0;
  endtask

  initial begin
    // R13: reset holds outputs low despite faulting inputs
    fv = 1; fpc = 32'h1001; mv = 1; mr = 2'd3;
    @(posedge clk); #1;
    expect_now("R13 reset", 0, 0, 0);
    @(posedge clk); #1;
    rst_n = 1; clear();
    step("R11 idle after reset");

    // R1 R2 R3: fetch PC low bits x response
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++) begin
        clear(); fv = 1; fpc = 32'h0000_4000 | p[31:0]; fr = r[1:0];
        step((p != 0) ? "R1 fetch misaligned" : (r != 0) ? "R2 R3 fetch fault" : "R3 fetch okay");
      end

    // R10: invalid stages ignored with faulting payloads
    clear(); fpc = 32'h3; fr = 2'd2; ill = 1; brk = 1; ecl = 1; csr = 1;
    maddr = 32'h1; msz = 2'd2; mr = 2'd3;
    step("R10 all stages idle");

    // R4 R5 R6 R9: decode flags x privilege
    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 4; p++) begin
        clear(); dv = 1; dpc = 32'h8000_0010 + f[31:0];
        {ill, brk, ecl} = f[2:0]; prv = p[1:0];
        step(f[2] ? "R4 illegal" : f[1] ? "R5 R9 break" : f[0] ? "R6 ecall" : "R11 clean decode");
      end

    // R4: execute bad CSR
    clear(); ev = 1; csr = 1; step("R4 csr illegal");

    // R7 R8 R3: memory size x low address x kind x response
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 4; a++)
        for (int k = 0; k < 4; k++)
          for (int r = 0; r < 4; r++) begin
            clear(); mv = 1; msz = s[1:0]; mk = k[1:0]; mr = r[1:0];
            maddr = 32'hC000_0100 | a[31:0];
            step("R7 R8 R3 memory sweep");
          end

    // R9: all overlaps of the four stages
    for (int m = 0; m < 16; m++) begin
      clear(); dpc = 32'h200;
      fv = m[0]; fpc = 32'h102;
      dv = m[1]; brk = m[1];
      ev = m[2]; csr = m[2];
      mv = m[3]; maddr = 32'h303; msz = 2'd1; mk = 2'd1;
      step("R9 stage priority");
    end

    // R12 R11: pulse ends once inputs go clean
    clear(); mv = 1; maddr = 32'h44; mr = 2'd1; step("R12 flush with trap");
    clear(); step("R12 R11 pulse drops");

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout, exp completion");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule